// File: doc/BRIEF.md
# Masked Flow Classifier

The block sorts packets into flows by comparing a 112-bit header key against a table of rule entries. Each entry holds a match value, a per-bit care mask, a 16-bit flow identifier and a valid bit. A mask bit of 1 means the key bit must equal the stored bit. A mask bit of 0 means the bit is ignored. Every entry is compared with the key at the same time. A priority encoder then picks one winner and returns its flow identifier.

Rules are loaded through a single write port that replaces one whole entry per cycle. Lookups can be issued on every cycle. Each lookup returns one result strobe, carrying a hit flag and the winning flow identifier, a fixed two cycles later. An upstream parser builds the key from the source and destination addresses, the source and destination ports, the protocol and eight payload content flags. A downstream stage acts on the result.

Top module: `flow_classifier`

## Requirements
- R1: The key is packed with the source address in bits [111:80], the destination address in [79:48], the source port in [47:32], the destination port in [31:16], the protocol in [15:8] and the content flags in [7:0]. Value and mask use the same layout. An entry matches when every key bit whose mask bit is 1 equals the stored value bit.
- R2: When several valid entries match, the result carries the flow identifier of the entry with the lowest index.
- R3: When no entry matches, `res_hit` is 0 and `res_flow` is 0 while `res_valid` is 1.
- R4: An entry written with `wr_valid` = 0 never matches, even when its mask is all zeros.
- R5: A lookup requested with `lk_req` high at a clock edge produces exactly one `res_valid` pulse, which appears two rising edges later. `res_valid` is never high without such a request.
- R6: A write and a lookup at the same edge: the lookup sees the table as it was before that write. A lookup issued on the next edge sees the new contents.
- R7: Reset (synchronous, `rst_n` low) marks every entry invalid and drives `res_valid`, `res_hit` and `res_flow` to 0.
- R8: A valid entry whose mask is all zeros matches any key.
- R9: Lookups issued on consecutive cycles each return their own result, in issue order, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one rule entry |
| wr_idx | input | $clog2(N_ENTRIES) | Entry index to write |
| wr_value | input | 112 | Match value for the entry |
| wr_mask | input | 112 | Care mask for the entry, 1 = compare |
| wr_flow | input | 16 | Flow identifier for the entry |
| wr_valid | input | 1 | Entry enable; 0 retires the entry |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 112 | Header key for the lookup |
| res_valid | output | 1 | Result strobe, two cycles after the request |
| res_hit | output | 1 | At least one entry matched |
| res_flow | output | 16 | Flow identifier of the winner, 0 on a miss |

## Verification
A corrupted entry, such as a flipped mask or value bit or a stale valid bit, shows up at the ports on the first lookup whose key touches that bit. It appears as a wrong hit flag or a wrong flow identifier two cycles after the request. A fault in the priority chain shows only when two or more entries match at once, so overlapping rules (a narrow rule, a prefix rule and a wildcard) are looked up together. A wrong pipeline depth or a lost strobe shows as a result strobe one cycle early or late, or as a missing result. The results of a back-to-back burst expose such faults on the first affected request.

// File: rtl/flowcls_pkg.sv
// Shared widths and the rule entry record for the flow classifier.
// Assumes a fixed 112-bit key: 32+32+16+16+8+8 bits.
package flowcls_pkg;
    localparam int ADDR_W  = 32;
    localparam int PORT_W  = 16;
    localparam int PROTO_W = 8;
    localparam int FLAG_W  = 8;
    localparam int KEY_W   = 2 * ADDR_W + 2 * PORT_W + PROTO_W + FLAG_W;
    localparam int FID_W   = 16;

    typedef struct packed {
        logic [KEY_W-1:0] value;
        logic [KEY_W-1:0] mask;
        logic [FID_W-1:0] flow;
        logic             valid;
    } rule_t;
endpackage

// File: rtl/rule_store.sv
// Rule table: one register record per entry, written one entry per cycle.
// Assumes wr_idx < N_ENTRIES. Reset clears only the valid bits.
module rule_store
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  rule_t                 wr_rule,
    output rule_t [N_ENTRIES-1:0] rules
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        // Update entry g when addressed; reset retires it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rules[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                rules[g] <= wr_rule;
            end
        end
    end
endmodule

// File: rtl/match_array.sv
// Parallel masked comparison of one key against every entry.
// Purely combinational; an invalid entry yields no match.
module match_array
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  rule_t [N_ENTRIES-1:0] rules,
    input  logic [KEY_W-1:0]      key,
    output logic [N_ENTRIES-1:0]  match_vec
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        // Cared-for bits that differ kill the match.
        assign match_vec[g] = rules[g].valid &&
                              (((key ^ rules[g].value) & rules[g].mask) == '0);
    end
endmodule

// File: rtl/prio_pick.sv
// Priority selection: lowest-indexed set bit wins and its flow is returned.
// Combinational; flow is zero when nothing is set.
module prio_pick
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic [N_ENTRIES-1:0]            match_vec,
    input  logic [N_ENTRIES-1:0][FID_W-1:0] flows,
    output logic                            found,
    output logic [FID_W-1:0]                flow
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        flow = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) flow = flows[i];
        end
        found = |match_vec;
    end
endmodule

// File: rtl/flow_classifier.sv
// Masked flow classifier top. Stage 1 registers the match vector and a
// snapshot of the flow IDs; stage 2 registers the priority-encoded result.
// Assumes N_ENTRIES >= 2. Latency from lk_req to res_valid is two edges.
module flow_classifier
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(N_ENTRIES)-1:0] wr_idx,
    input  logic [111:0]                 wr_value,
    input  logic [111:0]                 wr_mask,
    input  logic [15:0]                  wr_flow,
    input  logic                         wr_valid,
    input  logic                         lk_req,
    input  logic [111:0]                 lk_key,
    output logic                         res_valid,
    output logic                         res_hit,
    output logic [15:0]                  res_flow
);
    rule_t [N_ENTRIES-1:0]            rules;
    rule_t                            wr_rule;
    logic  [N_ENTRIES-1:0]            match_now;
    logic  [N_ENTRIES-1:0][FID_W-1:0] flows_now;
    logic                             s1_req;
    logic  [N_ENTRIES-1:0]            s1_match;
    logic  [N_ENTRIES-1:0][FID_W-1:0] s1_flows;
    logic                             pick_found;
    logic  [FID_W-1:0]                pick_flow;

    assign wr_rule = '{value: wr_value, mask: wr_mask, flow: wr_flow, valid: wr_valid};

    rule_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_rule (wr_rule),
        .rules   (rules)
    );

    match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
        .rules     (rules),
        .key       (lk_key),
        .match_vec (match_now)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flow
        assign flows_now[g] = rules[g].flow;
    end

    // Stage 1: capture match vector and flow IDs seen by this lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_req   <= 1'b0;
            s1_match <= '0;
            s1_flows <= '0;
        end else begin
            s1_req <= lk_req;
            if (lk_req) begin
                s1_match <= match_now;
                s1_flows <= flows_now;
            end
        end
    end

    prio_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .match_vec (s1_match),
        .flows     (s1_flows),
        .found     (pick_found),
        .flow      (pick_flow)
    );

    // Stage 2: register the encoded result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_flow  <= '0;
        end else begin
            res_valid <= s1_req;
            res_hit   <= s1_req && pick_found;
            res_flow  <= s1_req ? pick_flow : '0;
        end
    end
endmodule

// File: rtl/flow_classifier_chk.sv
// Port-level protocol checks for flow_classifier, attached by bind.
module flow_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_valid,
    input logic        lk_req,
    input logic        res_valid,
    input logic        res_hit,
    input logic [15:0] res_flow
);
    logic any_live;

    // Track whether any enabled entry has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) any_live <= 1'b0;
        else if (wr_en && wr_valid) any_live <= 1'b1;
    end

    AST_REQ_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> ##2 res_valid); // R5
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> ##2 !res_valid); // R5
    AST_MISS_FLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_flow == 16'd0)); // R3
    AST_HIT_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid); // R9
    AST_EMPTY_TABLE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |-> !res_hit); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_hit && res_flow == 16'd0)); // R7
endmodule

bind flow_classifier flow_classifier_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_valid  (wr_valid),
    .lk_req    (lk_req),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_flow  (res_flow)
);

// File: tb/test_flow_classifier.sv
module test_flow_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [111:0]  wr_value = '0;
    logic [111:0]  wr_mask = '0;
    logic [15:0]   wr_flow = '0;
    logic          wr_valid = 1'b0;
    logic          lk_req = 1'b0;
    logic [111:0]  lk_key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [15:0]   res_flow;

    flow_classifier #(.N_ENTRIES(N)) i_flow_classifier (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic        hit;
        logic [15:0] flow;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t         sb[$];
    int           checks = 0;
    int           fails = 0;
    int           cyc = 0;
    bit           done = 1'b0;
    logic [111:0] m_val  [N];
    logic [111:0] m_mask [N];
    logic [15:0]  m_flow [N];
    logic         m_vld  [N];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [111:0] mk_key(logic [31:0] s, logic [31:0] d,
            logic [15:0] sp, logic [15:0] dp, logic [7:0] pr, logic [7:0] ct);
        return {s, d, sp, dp, pr, ct};
    endfunction

    // Reference lookup built from R1, R2, R3, R4, R8.
    function automatic exp_t model(logic [111:0] k, string tag);
        exp_t e;
        e.hit = 1'b0; e.flow = '0; e.cyc = cyc + 2; e.tag = tag;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_vld[i] && (((k ^ m_val[i]) & m_mask[i]) == '0)) begin
                e.hit = 1'b1; e.flow = m_flow[i];
            end
        end
        return e;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    endtask

    task automatic do_write(int idx, logic [111:0] v, logic [111:0] m,
                            logic [15:0] f, logic vl);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_value = v; wr_mask = m;
        wr_flow = f; wr_valid = vl;
        m_val[idx] = v; m_mask[idx] = m; m_flow[idx] = f; m_vld[idx] = vl;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_lookup(logic [111:0] k, string tag);
        sb.push_back(model(k, tag));
        lk_req = 1'b1; lk_key = k;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // R6: write and lookup share one edge; expectation uses the old table.
    task automatic write_with_lookup(int idx, logic [111:0] v, logic [111:0] m,
                                     logic [15:0] f, logic [111:0] k, string tag);
        sb.push_back(model(k, tag));
        lk_req = 1'b1; lk_key = k;
        do_write(idx, v, m, f, 1'b1);
        lk_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: pops one expectation per result strobe.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R5 unrequested result: actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_hit !== e.hit || res_flow !== e.flow || cyc != e.cyc) begin
                    fails++;
                    $display("FAIL %s R5: actual hit=%0b flow=%h cyc=%0d expected hit=%0b flow=%h cyc=%0d",
                             e.tag, res_hit, res_flow, cyc, e.hit, e.flow, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [111:0] km;
        clear_model();
        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_mask[i] = '0; m_flow[i] = '0;
        end
        idle(3);
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_flow !== 16'h0) begin
            fails++;
            $display("FAIL R7 reset outputs: actual %b%b%h expected 000000", res_valid, res_hit, res_flow);
        end
        rst_n = 1'b1;
        idle(1);

        // R7: empty table after reset misses even a zero key.
        do_lookup('0, "R7 empty table");
        // R1: example rule in entry 3.
        do_write(3, mk_key(32'h80FC0000, 32'h8D8E0000, 16'h0, 16'h0050, 8'h06, 8'h01),
                    mk_key(32'hFFFF0000, 32'hFFFF0000, 16'h0, 16'hFFFF, 8'hFF, 8'h01), 16'h0103, 1'b1);
        km = mk_key(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01);
        do_lookup(km, "R1 rule hit");
        do_lookup(mk_key(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h11, 8'h01), "R1 R3 proto miss");
        do_lookup(mk_key(32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01), "R1 R3 src miss");
        do_lookup(mk_key(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h02), "R1 R3 flag miss");
        // R8: wildcard in entry 7.
        do_write(7, '0, '0, 16'h0777, 1'b1);
        do_lookup(mk_key(32'h01020304, 32'h0, 16'h0, 16'h0, 8'h11, 8'h00), "R8 wildcard");
        do_lookup(km, "R2 entry3 over entry7");
        // R2: prefix-only rule in entry 1 wins.
        do_write(1, mk_key(32'h80FC0000, 32'h0, 16'h0, 16'h0, 8'h0, 8'h0),
                    mk_key(32'hFFFF0000, 32'h0, 16'h0, 16'h0, 8'h0, 8'h0), 16'h0011, 1'b1);
        do_lookup(km, "R2 entry1 wins");
        // R4: retire entry 1, add disabled wildcard at 0.
        do_write(1, '0, '0, 16'h0011, 1'b0);
        do_write(0, '0, '0, 16'h0AAA, 1'b0);
        do_lookup(km, "R4 disabled entries skipped");
        // R6: same-edge write sees old table, next edge sees new.
        write_with_lookup(3, mk_key(32'h80FC0000, 32'h8D8E0000, 16'h0, 16'h0050, 8'h06, 8'h01),
                             mk_key(32'hFFFF0000, 32'hFFFF0000, 16'h0, 16'hFFFF, 8'hFF, 8'h01),
                             16'h0333, km, "R6 old contents");
        do_lookup(km, "R6 new contents");
        // R9: back-to-back burst.
        for (int i = 0; i < 6; i++) begin
            do_lookup(mk_key(32'h80FC0000 + i, 32'h8D8E0000, 16'h0, 16'h0050 + (i % 2), 8'h06, 8'h01),
                      "R9 burst");
        end
        idle(4);
        // R7: reset mid-run retires entries.
        rst_n = 1'b0; clear_model();
        idle(2);
        rst_n = 1'b1;
        do_lookup(km, "R7 after reset");
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R5 missing results: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule